// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block decides, once per clock, how the processor status changes when an exception is taken, when a handler returns, or when software writes the status word. Its inputs are a request vector with one bit per exception kind, the current status word and program counter, the saved status and link value of the current mode, a return request and a status-write request. Its outputs are registered write commands for the surrounding register storage: the new status word, the status to save and the mode whose save slot receives it, the link value and its mode, and the next program counter. A one-cycle `done` pulse marks each completed operation.

Taking an exception is one atomic update. The old status is saved into the target mode's slot. Both interrupt masks are set and the mode field switches. The link register of the target mode is loaded with a return address. The program counter jumps to the exception's vector. A return reverses this: the status comes back from the current mode's saved copy and the program counter from its link register. The register file and instruction fetch sit outside the block and consume the write enables.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first clock after release when no request is present, every write enable, `done` and `taken` are 0, and every data output is zero.
- R2: On entry, `save_stat` equals the status word sampled with the request, `save_we` is 1, and `save_mode` is the target mode.
- R3: On entry, `stat_nxt` equals the sampled status with bit 7 (normal-interrupt mask) and bit 6 (fast-interrupt mask) set and bits [4:0] replaced by the target mode. All other bits are unchanged. Mode codes are: user 0x10, fast interrupt 0x11, normal interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B, system 0x1F. The targets are: reset and software interrupt go to 0x13, both aborts go to 0x17, the fast interrupt goes to 0x11, the normal interrupt goes to 0x12, and undefined instruction goes to 0x1B.
- R4: On entry, `link_val` equals `pc_cur` minus a per-kind offset, `link_we` is 1, and `link_mode` is the target mode. The default offsets are 0 for reset, 8 for data abort, and 4 for every other kind.
- R5: On entry, `pc_nxt` is the kind's vector and `pc_we` is 1. The vectors are 0x00 for reset, 0x04 for undefined, 0x08 for software interrupt, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for normal interrupt and 0x1C for fast interrupt.
- R6: `exc_req` bit positions give the priority, with bit 0 highest. The bits are: 0 reset, 1 data abort, 2 fast interrupt, 3 normal interrupt, 4 prefetch abort, 5 software interrupt, 6 undefined. Only the highest eligible request is taken, and `taken` is its one-hot bit.
- R7: A normal-interrupt request is ignored while status bit 7 is 1. A fast-interrupt request is ignored while bit 6 is 1. The next eligible request is taken instead, or nothing if none is eligible.
- R8: Each operation shows on the outputs exactly one clock after its inputs are sampled, and `done` is high for that one cycle. The cycle after the inputs go idle, all enables and data outputs return to zero.
- R9: A return in a mode that has a saved status (0x11, 0x12, 0x13, 0x17 or 0x1B) gives `stat_nxt` = `saved_cur`, `pc_nxt` = `link_cur`, `stat_we` = `pc_we` = 1, and `save_we` = `link_we` = 0.
- R10: A return request in user mode, system mode or any other mode code is ignored. With no other request present, `done` stays 0.
- R11: In a privileged mode, a status write copies `swr_data` whole. In user mode, only bits [31:28] come from `swr_data` and bits [27:0] keep their current value, so the mode cannot change.
- R12: Precedence is entry over return over status write. The losing requests that cycle have no effect.
- R13: A software-interrupt request made in user mode enters supervisor mode 0x13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 7 | Exception requests, one bit per kind, in priority order |
| stat_cur | input | 32 | Current status word |
| pc_cur | input | 32 | Current program counter |
| saved_cur | input | 32 | Saved status of the current mode |
| link_cur | input | 32 | Link register of the current mode |
| ret_req | input | 1 | Handler return request |
| swr_req | input | 1 | Status write request |
| swr_data | input | 32 | Status write value |
| stat_nxt | output | 32 | New status word |
| stat_we | output | 1 | Status word write enable |
| save_stat | output | 32 | Status to store in the saved slot |
| save_we | output | 1 | Saved-status write enable |
| save_mode | output | 5 | Mode whose saved slot is written |
| link_val | output | 32 | Link register value |
| link_we | output | 1 | Link register write enable |
| link_mode | output | 5 | Mode whose link register is written |
| pc_nxt | output | 32 | Next program counter |
| pc_we | output | 1 | Program counter write enable |
| taken | output | 7 | One-hot kind of the exception taken |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that every input is stable around the sampling edge. They also assume that `stat_cur`, `saved_cur` and `link_cur` are the values of the mode the status names, so a return is judged against the mode field alone. The bench drives all inputs on the falling edge. Its random phase draws mode fields only from the seven defined codes and sets the mask bits at random, so masked and unmasked interrupts both occur. Directed cases add the undefined-mode return, the simultaneous request sets, and user-mode status writes whose data tries to change the mode.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int NKIND     = 7;
  localparam int KW        = $clog2(NKIND);
  localparam int MODE_W    = 5;
  localparam int FMASK_BIT = 6;
  localparam int IMASK_BIT = 7;
  localparam int SLOT_W    = 3;

  // Enumeration order is the priority order, highest first.
  typedef enum logic [KW-1:0] {
    K_RESET = 3'd0,
    K_DABT  = 3'd1,
    K_FIQ   = 3'd2,
    K_IRQ   = 3'd3,
    K_PABT  = 3'd4,
    K_SWI   = 3'd5,
    K_UNDEF = 3'd6
  } kind_e;

  typedef enum logic [MODE_W-1:0] {
    M_USER = 5'h10,
    M_FAST = 5'h11,
    M_NORM = 5'h12,
    M_SUPV = 5'h13,
    M_ABRT = 5'h17,
    M_UNDF = 5'h1B,
    M_SYST = 5'h1F
  } mode_e;

  function automatic logic [MODE_W-1:0] kind_to_mode(input kind_e k);
    case (k)
      K_RESET, K_SWI: return M_SUPV;
      K_DABT, K_PABT: return M_ABRT;
      K_FIQ:          return M_FAST;
      K_IRQ:          return M_NORM;
      default:        return M_UNDF;
    endcase
  endfunction

  // Word slot of each kind in the vector table.
  function automatic logic [SLOT_W-1:0] kind_to_slot(input kind_e k);
    case (k)
      K_RESET: return 3'd0;
      K_UNDEF: return 3'd1;
      K_SWI:   return 3'd2;
      K_PABT:  return 3'd3;
      K_DABT:  return 3'd4;
      K_IRQ:   return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic mode_has_saved(input logic [MODE_W-1:0] m);
    return (m == M_FAST) || (m == M_NORM) || (m == M_SUPV) ||
           (m == M_ABRT) || (m == M_UNDF);
  endfunction

  function automatic logic mode_is_priv(input logic [MODE_W-1:0] m);
    return m != M_USER;
  endfunction

endpackage

// File: rtl/trap_req_filter.sv
module trap_req_filter
  import trap_pkg::*;
#(
  parameter int N = NKIND
) (
  input  logic [N-1:0] raw,
  input  logic         imask,
  input  logic         fmask,
  output logic [N-1:0] eligible
);

  always_comb begin
    eligible                = raw;
    eligible[int'(K_IRQ)]   = raw[int'(K_IRQ)] & ~imask;
    eligible[int'(K_FIQ)]   = raw[int'(K_FIQ)] & ~fmask;
  end

endmodule

// File: rtl/trap_prio_arb.sv
module trap_prio_arb #(
  parameter  int N  = 7,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic          any,
  output logic [IW-1:0] idx
);

  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_rank
    assign grant[i]     = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end

  assign any = blocked[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/trap_update_calc.sv
module trap_update_calc
  import trap_pkg::*;
#(
  parameter int                  XLEN      = 32,
  parameter logic [XLEN-1:0]     VEC_BASE  = '0,
  parameter logic [NKIND*8-1:0]  BACK_PACK = '0
) (
  input  logic              take,
  input  logic [KW-1:0]     kind,
  input  logic              do_ret,
  input  logic              do_wr,
  input  logic [XLEN-1:0]   stat_cur,
  input  logic [XLEN-1:0]   pc_cur,
  input  logic [XLEN-1:0]   saved_cur,
  input  logic [XLEN-1:0]   link_cur,
  input  logic [XLEN-1:0]   swr_data,
  output logic [XLEN-1:0]   stat_d,
  output logic              stat_we_d,
  output logic [XLEN-1:0]   save_d,
  output logic              save_we_d,
  output logic [MODE_W-1:0] save_mode_d,
  output logic [XLEN-1:0]   link_d,
  output logic              link_we_d,
  output logic [MODE_W-1:0] link_mode_d,
  output logic [XLEN-1:0]   pc_d,
  output logic              pc_we_d
);

  localparam int FLAG_LSB = XLEN - 4;

  logic [7:0] back_tbl [NKIND];
  for (genvar k = 0; k < NKIND; k++) begin : g_back
    assign back_tbl[k] = BACK_PACK[k*8 +: 8];
  end

  function automatic logic [XLEN-1:0] entry_status(input logic [XLEN-1:0] s,
                                                   input logic [MODE_W-1:0] m);
    logic [XLEN-1:0] r;
    r              = s;
    r[IMASK_BIT]   = 1'b1;
    r[FMASK_BIT]   = 1'b1;
    r[MODE_W-1:0]  = m;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] return_address(input logic [XLEN-1:0] pc,
                                                     input logic [7:0] back);
    return pc - XLEN'(back);
  endfunction

  function automatic logic [XLEN-1:0] vector_address(input logic [SLOT_W-1:0] slot);
    return VEC_BASE + XLEN'({slot, 2'b00});
  endfunction

  function automatic logic [XLEN-1:0] user_write(input logic [XLEN-1:0] s,
                                                 input logic [XLEN-1:0] w);
    logic [XLEN-1:0] r;
    r                      = s;
    r[XLEN-1:FLAG_LSB]     = w[XLEN-1:FLAG_LSB];
    return r;
  endfunction

  logic [MODE_W-1:0] tgt_mode;
  kind_e             kind_k;

  always_comb begin
    kind_k      = kind_e'(kind);
    tgt_mode    = kind_to_mode(kind_k);
    stat_d      = '0;
    stat_we_d   = 1'b0;
    save_d      = '0;
    save_we_d   = 1'b0;
    save_mode_d = '0;
    link_d      = '0;
    link_we_d   = 1'b0;
    link_mode_d = '0;
    pc_d        = '0;
    pc_we_d     = 1'b0;
    if (take) begin
      save_d      = stat_cur;
      save_we_d   = 1'b1;
      save_mode_d = tgt_mode;
      stat_d      = entry_status(stat_cur, tgt_mode);
      stat_we_d   = 1'b1;
      link_d      = return_address(pc_cur, back_tbl[kind]);
      link_we_d   = 1'b1;
      link_mode_d = tgt_mode;
      pc_d        = vector_address(kind_to_slot(kind_k));
      pc_we_d     = 1'b1;
    end else if (do_ret) begin
      stat_d      = saved_cur;
      stat_we_d   = 1'b1;
      pc_d        = link_cur;
      pc_we_d     = 1'b1;
    end else if (do_wr) begin
      stat_d      = mode_is_priv(stat_cur[MODE_W-1:0]) ? swr_data
                                                       : user_write(stat_cur, swr_data);
      stat_we_d   = 1'b1;
    end
  end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] VEC_BASE   = '0,
  parameter int              BACK_RESET = 0,
  parameter int              BACK_DABT  = 8,
  parameter int              BACK_FIQ   = 4,
  parameter int              BACK_IRQ   = 4,
  parameter int              BACK_PABT  = 4,
  parameter int              BACK_SWI   = 4,
  parameter int              BACK_UNDEF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NKIND-1:0]  exc_req,
  input  logic [XLEN-1:0]   stat_cur,
  input  logic [XLEN-1:0]   pc_cur,
  input  logic [XLEN-1:0]   saved_cur,
  input  logic [XLEN-1:0]   link_cur,
  input  logic              ret_req,
  input  logic              swr_req,
  input  logic [XLEN-1:0]   swr_data,
  output logic [XLEN-1:0]   stat_nxt,
  output logic              stat_we,
  output logic [XLEN-1:0]   save_stat,
  output logic              save_we,
  output logic [MODE_W-1:0] save_mode,
  output logic [XLEN-1:0]   link_val,
  output logic              link_we,
  output logic [MODE_W-1:0] link_mode,
  output logic [XLEN-1:0]   pc_nxt,
  output logic              pc_we,
  output logic [NKIND-1:0]  taken,
  output logic              done
);

  // Offsets packed in kind order, kind 0 in the low byte.
  localparam logic [NKIND*8-1:0] BACK_PACK = {
    8'(BACK_UNDEF), 8'(BACK_SWI), 8'(BACK_PABT), 8'(BACK_IRQ),
    8'(BACK_FIQ),   8'(BACK_DABT), 8'(BACK_RESET)
  };

  // Named internal events, observed by the bound checker.
  logic [NKIND-1:0]  eligible_w;
  logic [NKIND-1:0]  grant_w;
  logic              take_w;
  logic [KW-1:0]     kind_idx_w;
  logic [MODE_W-1:0] cur_mode_w;
  logic              ret_ok_w;
  logic              wr_ok_w;

  assign cur_mode_w = stat_cur[MODE_W-1:0];

  trap_req_filter #(.N(NKIND)) u_filt (
    .raw      (exc_req),
    .imask    (stat_cur[IMASK_BIT]),
    .fmask    (stat_cur[FMASK_BIT]),
    .eligible (eligible_w)
  );

  trap_prio_arb #(.N(NKIND)) u_arb (
    .req   (eligible_w),
    .grant (grant_w),
    .any   (take_w),
    .idx   (kind_idx_w)
  );

  assign ret_ok_w = ret_req & ~take_w & mode_has_saved(cur_mode_w);
  assign wr_ok_w  = swr_req & ~take_w & ~ret_ok_w;

  logic [XLEN-1:0]   stat_d, save_d, link_d, pc_d;
  logic              stat_we_d, save_we_d, link_we_d, pc_we_d;
  logic [MODE_W-1:0] save_mode_d, link_mode_d;

  trap_update_calc #(
    .XLEN      (XLEN),
    .VEC_BASE  (VEC_BASE),
    .BACK_PACK (BACK_PACK)
  ) u_calc (
    .take        (take_w),
    .kind        (kind_idx_w),
    .do_ret      (ret_ok_w),
    .do_wr       (wr_ok_w),
    .stat_cur    (stat_cur),
    .pc_cur      (pc_cur),
    .saved_cur   (saved_cur),
    .link_cur    (link_cur),
    .swr_data    (swr_data),
    .stat_d      (stat_d),
    .stat_we_d   (stat_we_d),
    .save_d      (save_d),
    .save_we_d   (save_we_d),
    .save_mode_d (save_mode_d),
    .link_d      (link_d),
    .link_we_d   (link_we_d),
    .link_mode_d (link_mode_d),
    .pc_d        (pc_d),
    .pc_we_d     (pc_we_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_nxt  <= '0;
      stat_we   <= 1'b0;
      save_stat <= '0;
      save_we   <= 1'b0;
      save_mode <= '0;
      link_val  <= '0;
      link_we   <= 1'b0;
      link_mode <= '0;
      pc_nxt    <= '0;
      pc_we     <= 1'b0;
      taken     <= '0;
      done      <= 1'b0;
    end else begin
      stat_nxt  <= stat_d;
      stat_we   <= stat_we_d;
      save_stat <= save_d;
      save_we   <= save_we_d;
      save_mode <= save_mode_d;
      link_val  <= link_d;
      link_we   <= link_we_d;
      link_mode <= link_mode_d;
      pc_nxt    <= pc_d;
      pc_we     <= pc_we_d;
      taken     <= grant_w;
      done      <= take_w | ret_ok_w | wr_ok_w;
    end
  end

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NKIND-1:0]  exc_req,
  input logic [XLEN-1:0]   stat_cur,
  input logic [XLEN-1:0]   saved_cur,
  input logic [XLEN-1:0]   link_cur,
  input logic              ret_req,
  input logic              swr_req,
  input logic [NKIND-1:0]  grant_w,
  input logic              ret_ok_w,
  input logic [XLEN-1:0]   stat_nxt,
  input logic              stat_we,
  input logic [XLEN-1:0]   save_stat,
  input logic              save_we,
  input logic [MODE_W-1:0] save_mode,
  input logic              link_we,
  input logic [XLEN-1:0]   pc_nxt,
  input logic              pc_we,
  input logic [NKIND-1:0]  taken,
  input logic              done
);

  localparam int KEEP_HI = XLEN - 5;

  assert_onehot_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(taken));

  assert_grant_registered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_w) |=> (taken == $past(grant_w)) && done);

  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past((|exc_req) || ret_req || swr_req));

  assert_saved_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    save_we |-> (save_stat == $past(stat_cur)) && link_we);

  assert_entry_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    save_we |-> stat_we && stat_nxt[IMASK_BIT] && stat_nxt[FMASK_BIT] &&
                (stat_nxt[MODE_W-1:0] == save_mode));

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    taken[int'(K_IRQ)] |-> !$past(stat_cur[IMASK_BIT]));

  assert_fiq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    taken[int'(K_FIQ)] |-> !$past(stat_cur[FMASK_BIT]));

  assert_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok_w |=> pc_we && !save_we && (pc_nxt == $past(link_cur)) &&
                 (stat_nxt == $past(saved_cur)));

  assert_return_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && (exc_req == '0) && !swr_req &&
     ((stat_cur[MODE_W-1:0] == M_USER) || (stat_cur[MODE_W-1:0] == M_SYST)))
    |=> !done);

  assert_user_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (swr_req && (exc_req == '0) && !ret_req && (stat_cur[MODE_W-1:0] == M_USER))
    |=> stat_we && (stat_nxt[KEEP_HI:0] == $past(stat_cur[KEEP_HI:0])));

endmodule

bind trap_entry_ctrl trap_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .exc_req   (exc_req),
  .stat_cur  (stat_cur),
  .saved_cur (saved_cur),
  .link_cur  (link_cur),
  .ret_req   (ret_req),
  .swr_req   (swr_req),
  .grant_w   (grant_w),
  .ret_ok_w  (ret_ok_w),
  .stat_nxt  (stat_nxt),
  .stat_we   (stat_we),
  .save_stat (save_stat),
  .save_we   (save_we),
  .save_mode (save_mode),
  .link_we   (link_we),
  .pc_nxt    (pc_nxt),
  .pc_we     (pc_we),
  .taken     (taken),
  .done      (done)
);

// File: tb/trap_entry_ctrl_test.sv
`timescale 1ns/1ps
module trap_entry_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [6:0]  exc_req = '0;
  logic [31:0] stat_cur = '0, pc_cur = '0, saved_cur = '0, link_cur = '0, swr_data = '0;
  logic        ret_req = 1'b0, swr_req = 1'b0;

  logic [31:0] stat_nxt, save_stat, link_val, pc_nxt;
  logic        stat_we, save_we, link_we, pc_we, done;
  logic [4:0]  save_mode, link_mode;
  logic [6:0]  taken;

  trap_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .stat_cur(stat_cur), .pc_cur(pc_cur),
    .saved_cur(saved_cur), .link_cur(link_cur), .ret_req(ret_req), .swr_req(swr_req),
    .swr_data(swr_data), .stat_nxt(stat_nxt), .stat_we(stat_we), .save_stat(save_stat),
    .save_we(save_we), .save_mode(save_mode), .link_val(link_val), .link_we(link_we),
    .link_mode(link_mode), .pc_nxt(pc_nxt), .pc_we(pc_we), .taken(taken), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit armed  = 1'b0;

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Reference tables, written from the requirements.
  function automatic logic [4:0] mode_for(input int k);
    case (k)
      0, 5:    return 5'h13;
      1, 4:    return 5'h17;
      2:       return 5'h11;
      3:       return 5'h12;
      default: return 5'h1B;
    endcase
  endfunction

  function automatic logic [31:0] vec_for(input int k);
    case (k)
      0: return 32'h00;  1: return 32'h10;  2: return 32'h1C;  3: return 32'h18;
      4: return 32'h0C;  5: return 32'h08;  default: return 32'h04;
    endcase
  endfunction

  function automatic int back_for(input int k);
    return (k == 0) ? 0 : (k == 1) ? 8 : 4;
  endfunction

  // Expected outputs, produced at each rising edge.
  logic [31:0] e_stat, e_save, e_link, e_pc;
  logic        e_stat_we, e_save_we, e_link_we, e_pc_we, e_done;
  logic [4:0]  e_save_mode, e_link_mode;
  logic [6:0]  e_taken;
  int          e_op;
  bit          e_rst;
  int          pick;
  logic [4:0]  cm;
  int          order[$] = '{0, 1, 2, 3, 4, 5, 6};

  always @(posedge clk) begin
    e_stat = '0; e_save = '0; e_link = '0; e_pc = '0;
    e_stat_we = 0; e_save_we = 0; e_link_we = 0; e_pc_we = 0; e_done = 0;
    e_save_mode = '0; e_link_mode = '0; e_taken = '0; e_op = 0;
    e_rst = !rst_n;
    if (rst_n) begin
      pick = -1;
      foreach (order[q]) begin
        if (pick < 0 && exc_req[order[q]] &&
            !(order[q] == 3 && stat_cur[7]) && !(order[q] == 2 && stat_cur[6]))
          pick = order[q];
      end
      cm = stat_cur[4:0];
      if (pick >= 0) begin
        e_op = 1; e_done = 1; e_taken[pick] = 1'b1;
        e_save = stat_cur; e_save_we = 1; e_save_mode = mode_for(pick);
        e_stat = {stat_cur[31:8], 2'b11, stat_cur[5], mode_for(pick)}; e_stat_we = 1;
        e_link = pc_cur - 32'(back_for(pick)); e_link_we = 1; e_link_mode = mode_for(pick);
        e_pc = vec_for(pick); e_pc_we = 1;
      end else if (ret_req && (cm == 5'h11 || cm == 5'h12 || cm == 5'h13 ||
                               cm == 5'h17 || cm == 5'h1B)) begin
        e_op = 2; e_done = 1;
        e_stat = saved_cur; e_stat_we = 1; e_pc = link_cur; e_pc_we = 1;
      end else if (swr_req) begin
        e_op = 3; e_done = 1; e_stat_we = 1;
        e_stat = (cm == 5'h10) ? {swr_data[31:28], stat_cur[27:0]} : swr_data;
      end
    end
  end

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    if (armed) begin
      string ts, te, tl, tp, tg, td;
      if (e_rst) begin
        ts = "R1"; te = "R1"; tl = "R1"; tp = "R1"; tg = "R1"; td = "R1";
      end else begin
        case (e_op)
          1:       begin ts = "R3"; te = "R2"; tl = "R4"; tp = "R5"; tg = "R6"; td = "R8"; end
          2:       begin ts = "R9"; te = "R9"; tl = "R9"; tp = "R9"; tg = "R8"; td = "R8"; end
          3:       begin ts = "R11"; te = "R11"; tl = "R11"; tp = "R11"; tg = "R8"; td = "R8"; end
          default: begin ts = "R8"; te = "R8"; tl = "R8"; tp = "R8"; tg = "R8"; td = "R8"; end
        endcase
      end
      chk(ts, "stat_nxt", stat_nxt, e_stat);
      chk(ts, "stat_we", 32'(stat_we), 32'(e_stat_we));
      chk(te, "save_stat", save_stat, e_save);
      chk(te, "save_we", 32'(save_we), 32'(e_save_we));
      chk(te, "save_mode", 32'(save_mode), 32'(e_save_mode));
      chk(tl, "link_val", link_val, e_link);
      chk(tl, "link_we", 32'(link_we), 32'(e_link_we));
      chk(tl, "link_mode", 32'(link_mode), 32'(e_link_mode));
      chk(tp, "pc_nxt", pc_nxt, e_pc);
      chk(tp, "pc_we", 32'(pc_we), 32'(e_pc_we));
      chk(tg, "taken", 32'(taken), 32'(e_taken));
      chk(td, "done", 32'(done), 32'(e_done));
    end
  end

  // Apply inputs at a falling edge and wait until the result is visible.
  task automatic drv(input logic [6:0] rq, input logic [31:0] st, input logic [31:0] pc,
                     input logic [31:0] sv, input logic [31:0] lk, input logic rt,
                     input logic wr, input logic [31:0] wd);
    exc_req = rq; stat_cur = st; pc_cur = pc; saved_cur = sv; link_cur = lk;
    ret_req = rt; swr_req = wr; swr_data = wd;
    @(negedge clk);
  endtask

  task automatic idle();
    drv('0, '0, '0, '0, '0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    @(posedge clk);
    armed = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "done in reset", 32'(done), 32'h0);
    chk("R1", "stat_we in reset", 32'(stat_we), 32'h0);
    rst_n = 1'b1;
    idle();
    chk("R1", "pc_we after release", 32'(pc_we), 32'h0);

    // Normal interrupt from user mode.
    drv(7'b0001000, 32'h0000_0010, 32'h0000_1000, '0, '0, 0, 0, '0);
    chk("R3", "irq status", stat_nxt, 32'h0000_00D2);
    chk("R4", "irq link", link_val, 32'h0000_0FFC);
    chk("R5", "irq vector", pc_nxt, 32'h0000_0018);
    idle();
    chk("R8", "done drops", 32'(done), 32'h0);

    // Software interrupt from user mode.
    drv(7'b0100000, 32'hA000_0030, 32'h0000_2004, '0, '0, 0, 0, '0);
    chk("R13", "swi mode", 32'(stat_nxt[4:0]), 32'h13);
    chk("R5", "swi vector", pc_nxt, 32'h0000_0008);

    // Priority cases.
    drv(7'b1111111, 32'h0000_0010, 32'h0000_3000, '0, '0, 0, 0, '0);
    chk("R6", "all pending", 32'(taken), 32'h01);
    chk("R4", "reset link", link_val, 32'h0000_3000);
    drv(7'b0001110, 32'h0000_0010, 32'h0000_3000, '0, '0, 0, 0, '0);
    chk("R6", "dabt first", 32'(taken), 32'h02);
    chk("R4", "dabt link", link_val, 32'h0000_2FF8);
    drv(7'b0001100, 32'h0000_0010, 32'h0000_3000, '0, '0, 0, 0, '0);
    chk("R6", "fiq over irq", 32'(taken), 32'h04);
    drv(7'b1110000, 32'h0000_0013, 32'h0000_3000, '0, '0, 0, 0, '0);
    chk("R6", "pabt first", 32'(taken), 32'h10);

    // Masking.
    drv(7'b0101000, 32'h0000_0090, 32'h0000_4000, '0, '0, 0, 0, '0);
    chk("R7", "masked irq skips to swi", 32'(taken), 32'h20);
    drv(7'b0000100, 32'h0000_0050, 32'h0000_4000, '0, '0, 0, 0, '0);
    chk("R7", "masked fiq ignored", 32'(done), 32'h0);
    drv(7'b0001100, 32'h0000_0050, 32'h0000_4000, '0, '0, 0, 0, '0);
    chk("R7", "fiq masked irq open", 32'(taken), 32'h08);

    // Returns.
    drv('0, 32'h0000_00D2, '0, 32'h6000_0010, 32'h0000_2000, 1, 0, '0);
    chk("R9", "return status", stat_nxt, 32'h6000_0010);
    chk("R9", "return pc", pc_nxt, 32'h0000_2000);
    drv('0, 32'h0000_0010, '0, 32'h1234_5678, 32'h0000_5000, 1, 0, '0);
    chk("R10", "return in user", 32'(done), 32'h0);
    drv('0, 32'h0000_001F, '0, 32'h1234_5678, 32'h0000_5000, 1, 0, '0);
    chk("R10", "return in system", 32'(pc_we), 32'h0);
    drv('0, 32'h0000_0005, '0, 32'h1234_5678, 32'h0000_5000, 1, 0, '0);
    chk("R10", "return in unknown mode", 32'(done), 32'h0);

    // Status writes.
    drv('0, 32'h0000_0010, '0, '0, '0, 0, 1, 32'hF000_00DF);
    chk("R11", "user write", stat_nxt, 32'hF000_0010);
    drv('0, 32'h0000_0013, '0, '0, '0, 0, 1, 32'hF000_00DF);
    chk("R11", "privileged write", stat_nxt, 32'hF000_00DF);

    // Precedence.
    drv(7'b1000000, 32'h0000_0012, 32'h0000_6000, 32'h0000_0010, 32'h0000_7000, 1, 1, 32'h0);
    chk("R12", "entry beats return", pc_nxt, 32'h0000_0004);
    drv('0, 32'h0000_0012, '0, 32'h0000_0010, 32'h0000_7000, 1, 1, 32'hFFFF_FFFF);
    chk("R12", "return beats write", stat_nxt, 32'h0000_0010);

    // Random traffic, compared every cycle.
    for (int n = 0; n < 3000; n++) begin
      logic [4:0]  modes [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
      logic [31:0] st;
      logic [6:0]  rq;
      st = $urandom();
      st[4:0] = modes[$urandom_range(0, 6)];
      rq = ($urandom_range(0, 2) == 0) ? 7'(1 << $urandom_range(0, 6)) :
           ($urandom_range(0, 1) == 0) ? 7'($urandom()) & 7'h7E : '0;
      drv(rq, st, $urandom(), $urandom(), $urandom(),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom());
    end
    idle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule